// File: doc/BRIEF.md
# Timed-Retune Oscillator Phase Controller

This block sits in a complex sample stream and attaches to every sample the current phase of a numerically controlled oscillator. A downstream stage, not part of this block, turns that phase into a sine/cosine pair and rotates the sample with it. Samples, their end-of-packet marker and their sideband word pass straight through with ordinary valid/ready flow control. The phase moves forward by the increment only when a beat is actually accepted.

The phase increment is set through a small configuration write port that carries an address, a data word, a 64-bit due time and a flag that marks the write as timed. An untimed write to the frequency address replaces the increment at once. A timed write goes into a short in-order command queue, and a full flag reports when the queue cannot take another entry. Every sample of a timed packet has a time of its own: the 64-bit stamp in the sideband word plus its position in the packet. Once a sample whose time has reached the due time of the oldest queued command is accepted, the new increment is installed and the accumulator restarts from zero.

The accumulator also restarts at the first sample of every burst, so each burst begins at phase zero. A synchronous clear empties the command queue and zeroes the accumulator.

Top module: `nco_tune_ctrl`

## Requirements
- R1: The phase shown with a sample is the accumulator value before that sample's increment is added. The accumulator advances by the increment only on an accepted beat (in_valid and out_ready both high). Data, last and sideband pass through unchanged, with out_valid equal to in_valid and in_ready equal to out_ready.
- R2: The phase is zero for the first sample after reset and for the first sample after a packet whose last beat had sideband bit 124 (end of burst) set.
- R3: An untimed write (cfg_timed low) to address FREQ_ADDR (default 132) loads the increment at that clock edge. A beat accepted in the same cycle still adds the old increment. Writes to any other address have no effect.
- R4: A sample's time is sideband bits 63:0 of its packet plus the sample's index within the packet. The first beat of a packet has index 0.
- R5: A timed write to FREQ_ADDR with due time T is queued. The sample whose time is T still uses the old increment. The next sample has phase zero, and the new increment applies from the sample after that.
- R6: Queued commands are applied oldest first, at most one per accepted sample. cmdq_full is high while QDEPTH commands are held, and a timed write made while the queue is full is dropped.
- R7: Commands are matched only against samples of timed packets (sideband bit 125 set). A command whose due time is already in the past is applied at the next accepted timed sample.
- R8: A clr pulse empties the command queue and zeroes the accumulator, so the next sample has phase zero.
- R9: If an untimed frequency write and a queued command both land in the same cycle, the queued command's increment wins.
- R10: The accumulator wraps modulo 2^32, so an increment written as a negative fraction steps the phase downward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous clear of command queue and accumulator |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Configuration address |
| cfg_data | input | 32 | Configuration data (phase increment) |
| cfg_time | input | 64 | Due time of a timed write |
| cfg_timed | input | 1 | Write is timed (queued) |
| cmdq_full | output | 1 | Command queue holds QDEPTH entries |
| in_data | input | SAMPLE_W | Input complex sample |
| in_last | input | 1 | Last beat of packet |
| in_user | input | USER_W | Sideband: 63:0 timestamp, 124 end of burst, 125 timed |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with in_valid |
| out_data | output | SAMPLE_W | Output sample |
| out_last | output | 1 | Output last beat |
| out_user | output | USER_W | Output sideband |
| out_phase | output | 32 | Oscillator phase for this sample |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream ready |

## Verification
The bench tries a retune landing in the middle of a packet, on a packet's last sample and on a packet's first sample. A design that used the wrong time or got the off-by-one wrong would put the zero phase on the wrong sample, or would let the tuned sample already use the new increment. It fills the queue and then writes once more, so a design that accepted the extra write would apply a stray fifth retune. It sends an untimed packet while a command is pending, so a design that ignored the timed bit would retune there. It stalls the output with a beat held valid; a design that advanced on valid alone would skip phases. It also checks a command whose due time is long past, two commands in a row that must apply in order, an immediate write colliding with a queued command, a clear in the middle of a burst, and a negative increment that must wrap.

// File: rtl/nco_pkg.sv
// Shared widths and the queued retune command type.
// Assumes a 64-bit sample clock and a 32-bit phase word.
package nco_pkg;
    localparam int NCO_TIME_W  = 64;
    localparam int NCO_PHASE_W = 32;

    typedef struct packed {
        logic [NCO_TIME_W-1:0]  due;
        logic [NCO_PHASE_W-1:0] step;
    } tune_cmd_t;
endpackage

// File: rtl/nco_cmd_fifo.sv
// In-order queue of timed retune commands.
// Assumes: a push while full is dropped; a pop while empty is ignored;
// clr has priority over push and pop.
module nco_cmd_fifo
    import nco_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      clr,
    input  logic      push,
    input  tune_cmd_t push_cmd,
    input  logic      pop,
    output tune_cmd_t head,
    output logic      empty,
    output logic      full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    tune_cmd_t       mem [DEPTH];
    logic [PW-1:0]   wr_q, rd_q;
    logic [CW-1:0]   cnt_q;
    logic            do_push, do_pop;

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == CW'(DEPTH));
    assign do_push = push && !full && !clr;
    assign do_pop  = pop && !empty && !clr;
    assign head    = mem[rd_q];

    function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    // Storage write; entries need no reset.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_q] <= push_cmd;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wr_q <= wrap_inc(wr_q);
            if (do_pop)  rd_q <= wrap_inc(rd_q);
            cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
        end
    end
endmodule

// File: rtl/nco_sample_clock.sv
// Derives each sample's time from the packet stamp plus index, and marks
// the first sample of a burst.
// Assumes the sideband word is constant across a packet.
module nco_sample_clock
    import nco_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  beat,
    input  logic                  last,
    input  logic                  eob,
    input  logic [NCO_TIME_W-1:0] stamp,
    output logic [NCO_TIME_W-1:0] sample_time,
    output logic                  burst_start
);
    logic                  sop_q;
    logic [NCO_TIME_W-1:0] next_q;

    // R4: first beat takes the stamp, later beats count on from it.
    assign sample_time = sop_q ? stamp : next_q;

    // Track packet and burst position across accepted beats.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sop_q       <= 1'b1;
            burst_start <= 1'b1;
            next_q      <= '0;
        end else if (beat) begin
            sop_q       <= last;
            burst_start <= last && eob;
            next_q      <= sample_time + NCO_TIME_W'(1);
        end
    end
endmodule

// File: rtl/nco_phase_acc.sv
// Phase accumulator and increment register.
// Assumes retune is only raised on an accepted beat; retune beats an
// immediate load in the same cycle (R9).
module nco_phase_acc
    import nco_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr,
    input  logic                   beat,
    input  logic                   burst_start,
    input  logic                   retune,
    input  logic [NCO_PHASE_W-1:0] retune_step,
    input  logic                   load,
    input  logic [NCO_PHASE_W-1:0] load_step,
    output logic [NCO_PHASE_W-1:0] phase
);
    logic [NCO_PHASE_W-1:0] acc_q, step_q;

    // Phase seen by the current sample: zero at a burst's first sample.
    assign phase = burst_start ? '0 : acc_q;

    // Advance on accepted beats; wraps modulo 2^32 (R10).
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc_q <= '0;
        end else if (beat) begin
            acc_q <= retune ? '0 : phase + step_q;
        end
    end

    // Increment register: queued retune first, then immediate load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= '0;
        end else if (retune) begin
            step_q <= retune_step;
        end else if (load) begin
            step_q <= load_step;
        end
    end
endmodule

// File: rtl/nco_tune_ctrl.sv
// Top: passes samples through and tags each with an oscillator phase;
// decodes configuration writes into immediate loads or queued retunes.
// Assumes the sideband word holds a 64-bit stamp in its low bits.
module nco_tune_ctrl
    import nco_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int FREQ_ADDR = 132,
    parameter int QDEPTH    = 4,
    parameter int SAMPLE_W  = 32,
    parameter int USER_W    = 128,
    parameter int EOB_BIT   = 124,
    parameter int TIMED_BIT = 125
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr,
    input  logic                   cfg_we,
    input  logic [ADDR_W-1:0]      cfg_addr,
    input  logic [NCO_PHASE_W-1:0] cfg_data,
    input  logic [NCO_TIME_W-1:0]  cfg_time,
    input  logic                   cfg_timed,
    output logic                   cmdq_full,
    input  logic [SAMPLE_W-1:0]    in_data,
    input  logic                   in_last,
    input  logic [USER_W-1:0]      in_user,
    input  logic                   in_valid,
    output logic                   in_ready,
    output logic [SAMPLE_W-1:0]    out_data,
    output logic                   out_last,
    output logic [USER_W-1:0]      out_user,
    output logic [NCO_PHASE_W-1:0] out_phase,
    output logic                   out_valid,
    input  logic                   out_ready
);
    logic                  beat, freq_hit, imm_load, q_push, retune;
    logic                  q_empty, burst_start;
    logic [NCO_TIME_W-1:0] sample_time;
    tune_cmd_t             q_head;

    // R1: straight pass-through with shared handshake.
    assign out_data  = in_data;
    assign out_last  = in_last;
    assign out_user  = in_user;
    assign out_valid = in_valid;
    assign in_ready  = out_ready;
    assign beat      = in_valid && out_ready;

    // R3 / R5: address decode into immediate or queued writes.
    assign freq_hit = cfg_we && (cfg_addr == ADDR_W'(FREQ_ADDR));
    assign imm_load = freq_hit && !cfg_timed;
    assign q_push   = freq_hit && cfg_timed;

    // R5 / R7: oldest command fires once a timed sample reaches its time.
    assign retune = beat && !clr && !q_empty && in_user[TIMED_BIT]
                    && (q_head.due <= sample_time);

    nco_cmd_fifo #(.DEPTH(QDEPTH)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .push     (q_push),
        .push_cmd ('{due: cfg_time, step: cfg_data}),
        .pop      (retune),
        .head     (q_head),
        .empty    (q_empty),
        .full     (cmdq_full)
    );

    nco_sample_clock u_sclk (
        .clk         (clk),
        .rst_n       (rst_n),
        .beat        (beat),
        .last        (in_last),
        .eob         (in_user[EOB_BIT]),
        .stamp       (in_user[NCO_TIME_W-1:0]),
        .sample_time (sample_time),
        .burst_start (burst_start)
    );

    nco_phase_acc u_acc (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (clr),
        .beat        (beat),
        .burst_start (burst_start),
        .retune      (retune),
        .retune_step (q_head.step),
        .load        (imm_load),
        .load_step   (cfg_data),
        .phase       (out_phase)
    );
endmodule

// File: rtl/nco_tune_ctrl_chk.sv
// Temporal checks on the phase controller's ports, bound to the top.
module nco_tune_ctrl_chk
    import nco_pkg::*;
#(
    parameter int USER_W  = 128,
    parameter int EOB_BIT = 124
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   clr,
    input logic                   in_valid,
    input logic                   in_last,
    input logic [USER_W-1:0]      in_user,
    input logic                   out_ready,
    input logic [NCO_PHASE_W-1:0] out_phase,
    input logic                   cmdq_full
);
    // R1
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !out_ready && !clr) |=> $stable(out_phase));

    // R2
    burst_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && out_ready && in_last && in_user[EOB_BIT]) |=> (out_phase == '0));

    // R6
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmdq_full && !(in_valid && out_ready) && !clr) |=> cmdq_full);

    // R8
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!cmdq_full && out_phase == '0));
endmodule

bind nco_tune_ctrl nco_tune_ctrl_chk #(.USER_W(USER_W), .EOB_BIT(EOB_BIT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .in_valid  (in_valid),
    .in_last   (in_last),
    .in_user   (in_user),
    .out_ready (out_ready),
    .out_phase (out_phase),
    .cmdq_full (cmdq_full)
);

// File: tb/nco_tune_ctrl_test.sv
module nco_tune_ctrl_test;
    localparam int DEPTH = 4;
    localparam int FADDR = 132;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         clr = 1'b0;
    logic         cfg_we = 1'b0;
    logic [7:0]   cfg_addr = '0;
    logic [31:0]  cfg_data = '0;
    logic [63:0]  cfg_time = '0;
    logic         cfg_timed = 1'b0;
    logic         cmdq_full;
    logic [31:0]  in_data = '0;
    logic         in_last = 1'b0;
    logic [127:0] in_user = '0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [31:0]  out_data;
    logic         out_last;
    logic [127:0] out_user;
    logic [31:0]  out_phase;
    logic         out_valid;
    logic         out_ready = 1'b1;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    nco_tune_ctrl uut (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .cfg_time(cfg_time), .cfg_timed(cfg_timed), .cmdq_full(cmdq_full),
        .in_data(in_data), .in_last(in_last), .in_user(in_user),
        .in_valid(in_valid), .in_ready(in_ready),
        .out_data(out_data), .out_last(out_last), .out_user(out_user),
        .out_phase(out_phase), .out_valid(out_valid), .out_ready(out_ready)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Behavioural reference model, stepped once per cycle.
    logic [31:0] m_acc, m_inc;
    logic [63:0] m_next;
    bit          m_sop, m_sob;
    logic [63:0] qt[$];
    logic [31:0] qi[$];
    logic [31:0] obs[$];

    always @(negedge clk) begin
        if (!rst_n) begin
            m_acc = '0; m_inc = '0; m_next = '0; m_sop = 1; m_sob = 1;
            qt.delete(); qi.delete();
        end else begin
            logic [31:0] ph;
            logic [63:0] st;
            bit beat, hit, wasfull, fw;
            ph = m_sob ? 32'd0 : m_acc;
            st = m_sop ? in_user[63:0] : m_next;
            chk(out_phase == ph, "R1 R2 R5 phase", {32'd0, out_phase}, {32'd0, ph});
            chk(out_valid == in_valid && in_ready == out_ready && out_data == in_data
                && out_last == in_last && out_user == in_user, "R1 passthrough",
                {31'd0, out_valid, out_data}, {31'd0, in_valid, in_data});
            chk(cmdq_full == (qt.size() == DEPTH), "R6 full flag",
                {63'd0, cmdq_full}, {63'd0, qt.size() == DEPTH});
            beat = in_valid && out_ready;
            if (beat) obs.push_back(out_phase);
            hit = beat && !clr && qt.size() > 0 && in_user[125] && qt[0] <= st;
            wasfull = (qt.size() == DEPTH);
            fw = cfg_we && cfg_addr == 8'(FADDR);
            if (beat) m_acc = hit ? 32'd0 : ph + m_inc;
            if (hit) begin
                m_inc = qi[0];
                void'(qt.pop_front()); void'(qi.pop_front());
            end else if (fw && !cfg_timed) begin
                m_inc = cfg_data;
            end
            if (clr) begin
                qt.delete(); qi.delete(); m_acc = '0;
            end else if (fw && cfg_timed && !wasfull) begin
                qt.push_back(cfg_time); qi.push_back(cfg_data);
            end
            if (beat) begin
                m_next = st + 64'd1; m_sop = in_last; m_sob = in_last && in_user[124];
            end
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input bit timed, input logic [63:0] t);
        cfg_we = 1; cfg_addr = a; cfg_data = d; cfg_timed = timed; cfg_time = t;
        tick();
        cfg_we = 0; cfg_timed = 0;
    endtask

    task automatic pulse_clr();
        clr = 1; tick(); clr = 0;
    endtask

    task automatic send_pkt(input logic [63:0] ts, input int len, input bit timed, input bit eob,
                            input bit stall, input int imm_at, input logic [31:0] imm_val);
        for (int i = 0; i < len; i++) begin
            in_data = ts[31:0] + 32'(i) * 32'h0001_0003;
            in_last = (i == len - 1);
            in_user = '0;
            in_user[63:0] = ts;
            in_user[124] = eob;
            in_user[125] = timed;
            in_valid = 1;
            if (stall && i % 2 == 1) begin
                out_ready = 0;
                tick();
                out_ready = 1;
            end
            if (i == imm_at) begin
                cfg_we = 1; cfg_addr = 8'(FADDR); cfg_data = imm_val; cfg_timed = 0;
            end
            tick();
            cfg_we = 0;
        end
        in_valid = 0; in_last = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1;
        tick();
        // Reset state
        chk(cmdq_full == 0, "R6 reset empty", {63'd0, cmdq_full}, 64'd0);
        chk(out_phase == 0, "R2 reset phase", {32'd0, out_phase}, 64'd0);

        // R1 R3 R4: immediate increment, stalled beats
        wr(8'(FADDR), 32'h1000_0000, 0, 0);
        obs.delete();
        send_pkt(0, 4, 1, 0, 1, -1, 0);
        send_pkt(4, 4, 1, 1, 1, -1, 0);
        chk(obs[4] == 32'h4000_0000, "R1 step", {32'd0, obs[4]}, 64'h4000_0000);
        chk(obs[7] == 32'h7000_0000, "R1 stall step", {32'd0, obs[7]}, 64'h7000_0000);
        obs.delete();
        send_pkt(8, 3, 1, 1, 0, -1, 0);
        chk(obs[0] == 0, "R2 burst restart", {32'd0, obs[0]}, 64'd0);

        // R5 R4: retune mid-packet
        wr(8'(FADDR), 32'h0300_0000, 1, 204);
        obs.delete();
        send_pkt(200, 10, 1, 1, 0, -1, 0);
        chk(obs[4] == 32'h4000_0000, "R5 old step at T", {32'd0, obs[4]}, 64'h4000_0000);
        chk(obs[5] == 0, "R4 restart after T", {32'd0, obs[5]}, 64'd0);
        chk(obs[7] == 32'h0600_0000, "R5 new step", {32'd0, obs[7]}, 64'h0600_0000);

        // R5: retune on last sample of a packet
        wr(8'(FADDR), 32'h0100_0000, 1, 303);
        obs.delete();
        send_pkt(300, 4, 1, 0, 0, -1, 0);
        send_pkt(304, 3, 1, 1, 0, -1, 0);
        chk(obs[3] == 32'h0900_0000, "R5 last sample old", {32'd0, obs[3]}, 64'h0900_0000);
        chk(obs[4] == 0, "R5 next packet restart", {32'd0, obs[4]}, 64'd0);
        chk(obs[5] == 32'h0100_0000, "R5 next packet new", {32'd0, obs[5]}, 64'h0100_0000);

        // R5: retune on first sample
        wr(8'(FADDR), 32'h0050_0000, 1, 400);
        obs.delete();
        send_pkt(400, 3, 1, 1, 0, -1, 0);
        chk(obs[1] == 0 && obs[2] == 32'h0050_0000, "R5 first sample", {32'd0, obs[2]}, 64'h0050_0000);

        // R7: past-due command
        wr(8'(FADDR), 32'h0000_1000, 1, 10);
        obs.delete();
        send_pkt(500, 3, 1, 1, 0, -1, 0);
        chk(obs[2] == 32'h0000_1000, "R7 past due", {32'd0, obs[2]}, 64'h1000);

        // R6: in-order application
        wr(8'(FADDR), 32'h0000_0100, 1, 600);
        wr(8'(FADDR), 32'h0000_0010, 1, 601);
        obs.delete();
        send_pkt(600, 4, 1, 1, 0, -1, 0);
        chk(obs[3] == 32'h10, "R6 order", {32'd0, obs[3]}, 64'h10);

        // R6: full flag and dropped write
        for (int k = 0; k < 4; k++) wr(8'(FADDR), 32'(k + 1), 1, 64'(1000 + k));
        chk(cmdq_full == 1, "R6 full", {63'd0, cmdq_full}, 64'd1);
        wr(8'(FADDR), 32'd5, 1, 1000);
        obs.delete();
        send_pkt(1000, 6, 1, 1, 0, -1, 0);
        chk(obs[5] == 32'd4, "R6 drop when full", {32'd0, obs[5]}, 64'd4);

        // R7: untimed packet does not retune
        wr(8'(FADDR), 32'd2, 1, 700);
        obs.delete();
        send_pkt(700, 3, 0, 1, 0, -1, 0);
        chk(obs[2] == 32'd8, "R7 untimed ignored", {32'd0, obs[2]}, 64'd8);

        // R8: clear empties queue and zeroes accumulator
        pulse_clr();
        obs.delete();
        send_pkt(900, 3, 1, 0, 0, -1, 0);
        chk(obs[2] == 32'd8, "R8 queue emptied", {32'd0, obs[2]}, 64'd8);
        pulse_clr();
        obs.delete();
        send_pkt(903, 2, 1, 1, 0, -1, 0);
        chk(obs[0] == 0 && obs[1] == 32'd4, "R8 acc zeroed", {32'd0, obs[1]}, 64'd4);

        // R9: queued retune beats a concurrent immediate write
        wr(8'(FADDR), 32'h100, 1, 1100);
        obs.delete();
        send_pkt(1100, 3, 1, 1, 0, 0, 32'h999);
        chk(obs[2] == 32'h100, "R9 retune wins", {32'd0, obs[2]}, 64'h100);

        // R3: immediate write mid-packet applies after that beat
        obs.delete();
        send_pkt(1150, 4, 1, 1, 0, 1, 32'h200);
        chk(obs[2] == 32'h200, "R3 same-cycle beat old step", {32'd0, obs[2]}, 64'h200);
        chk(obs[3] == 32'h400, "R3 new step", {32'd0, obs[3]}, 64'h400);

        // R3 other address ignored, R10 wrap
        wr(8'd133, 32'h1234, 0, 0);
        wr(8'(FADDR), 32'hC000_0000, 0, 0);
        obs.delete();
        send_pkt(1200, 4, 1, 1, 0, -1, 0);
        chk(obs[1] == 32'hC000_0000, "R3 other addr ignored", {32'd0, obs[1]}, 64'hC000_0000);
        chk(obs[3] == 32'h4000_0000, "R10 wrap", {32'd0, obs[3]}, 64'h4000_0000);

        repeat (4) tick();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule